// File: doc/BRIEF.md
# Strobed Output Channel with Acknowledge Handshake

This block is one 8-bit output channel of a parallel peripheral port. The processor hands it a byte with a single-cycle write strobe; the channel captures the byte into a latch that drives the output pins. It then pulls an active-low "buffer full" line to the external device, telling it that fresh data is waiting.

The device takes the byte and answers with an active-low acknowledge pulse. The channel brings that pulse through a synchroniser and detects its edges on the system clock. The falling edge releases the buffer-full line. The rising edge raises an interrupt request, but only if the acknowledge really consumed a pending byte and the interrupt-enable bit is set. So the processor can learn that the peripheral has taken the data without polling.

The write path is a data stream with no back-pressure. Every cycle with `wr_valid` high is accepted. A write while the buffer is still full replaces the byte and keeps the line low. The interrupt-enable bit has its own plain write path.

Top module: `strobed_out_chan`

## Requirements
- R1: One clock edge after a cycle with `wr_valid` high, `pdata` equals the `wr_data` presented in that cycle.
- R2: One clock edge after a write, `obf_n` is 0 (buffer full).
- R3: `obf_n` stays 0 until `ack_n` falls. With the default two synchroniser stages, `obf_n` returns to 1 on the third clock edge after `ack_n` goes low. It is still 0 after the second edge.
- R4: If an acknowledge cleared a pending byte and the enable is 1, `irq` goes to 1 on the third clock edge after `ack_n` returns high.
- R5: With the enable at 0, a full acknowledge cycle leaves `irq` at 0.
- R6: A write clears `irq` on the next clock edge.
- R7: Writing 0 to the interrupt enable (`ie_wr`=1, `ie_data`=0) clears `irq` on the next edge.
- R8: An acknowledge pulse with no pending byte (`obf_n` already 1) keeps `obf_n` at 1 and raises no interrupt.
- R9: While `rst_n` is 0: `obf_n`=1, `irq`=0, `pdata`=0, and the enable is 0.
- R10: `pdata` holds its value in every cycle without a write. A write while `obf_n` is 0 replaces `pdata` and keeps `obf_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Processor write of the data byte; always accepted |
| wr_data | input | 8 | Byte to latch |
| ie_wr | input | 1 | Write strobe for the interrupt-enable bit |
| ie_data | input | 1 | New interrupt-enable value |
| ack_n | input | 1 | Asynchronous active-low acknowledge from the device |
| pdata | output | 8 | Latched output pins |
| obf_n | output | 1 | Active-low buffer-full indication to the device |
| irq | output | 1 | Interrupt request: the peripheral has taken the data |

## Verification
The checker enforces these rules on every cycle:
- a write is latched and marks the buffer full;
- the latch is stable between writes;
- the full line cannot release without a detected acknowledge edge;
- a request can only rise with the enable set and the buffer empty;
- writes and enable clears drop the request.

Only the bench's scenarios can show the rest:
- the exact three-edge latency through the synchroniser;
- that the request follows a genuine transfer and not a stray acknowledge;
- that the enable value carried through each vector gives the request it should.

// File: rtl/strobed_out_pkg.sv
package strobed_out_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/ack_edge_sync.sv
module ack_edge_sync
  import strobed_out_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ack_n,
  output edge_t ack_edge
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[CHAIN-2:0], ack_n};
  end

  // chain_q[STAGES-1] is the synchronised level; chain_q[STAGES] is its previous value
  assign ack_edge.fall = chain_q[STAGES] & ~chain_q[STAGES-1];
  assign ack_edge.rise = ~chain_q[STAGES] & chain_q[STAGES-1];
endmodule

// File: rtl/out_latch.sv
module out_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import strobed_out_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  logic  ie_wr,
  input  logic  ie_data,
  input  edge_t ack_edge,
  output logic  full_n,
  output logic  ie,
  output logic  irq
);
  logic taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_n  <= 1'b1;
      taken_q <= 1'b0;
    end else if (wr) begin
      full_n  <= 1'b0;
      taken_q <= 1'b0;
    end else if (ack_edge.fall) begin
      taken_q <= ~full_n;
      full_n  <= 1'b1;
    end else if (ack_edge.rise) begin
      taken_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie <= 1'b0;
    else if (ie_wr) ie <= ie_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      irq <= 1'b0;
    else if (wr)                     irq <= 1'b0;
    else if (ie_wr && !ie_data)      irq <= 1'b0;
    else if (ack_edge.rise && taken_q && full_n && ie)
                                     irq <= 1'b1;
  end
endmodule

// File: rtl/strobed_out_chan.sv
module strobed_out_chan
  import strobed_out_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             ie_wr,
  input  logic             ie_data,
  input  logic             ack_n,
  output logic [WIDTH-1:0] pdata,
  output logic             obf_n,
  output logic             irq
);
  edge_t ack_edge;
  logic  ie_q;

  ack_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .ack_edge(ack_edge)
  );

  out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(wr_valid), .din(wr_data), .dout(pdata)
  );

  hs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_valid), .ie_wr(ie_wr), .ie_data(ie_data),
    .ack_edge(ack_edge), .full_n(obf_n), .ie(ie_q), .irq(irq)
  );
endmodule

// File: rtl/strobed_out_chan_chk.sv
module strobed_out_chan_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic [WIDTH-1:0] wr_data,
  input logic             ie_wr,
  input logic             ie_data,
  input logic             ie_q,
  input logic             ack_fall,
  input logic [WIDTH-1:0] pdata,
  input logic             obf_n,
  input logic             irq
);
  a_r1_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> pdata == $past(wr_data));
  a_r2_full_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !obf_n);
  a_r3_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!obf_n && !ack_fall) |=> !obf_n);
  a_r5_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ie_q && obf_n));
  a_r6_write_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !irq);
  a_r7_ie_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_wr && !ie_data) |=> !irq);
  a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(pdata));
endmodule

bind strobed_out_chan strobed_out_chan_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
  .ie_wr(ie_wr), .ie_data(ie_data), .ie_q(ie_q), .ack_fall(ack_edge.fall),
  .pdata(pdata), .obf_n(obf_n), .irq(irq)
);

// File: tb/test_strobed_out_chan.sv
module test_strobed_out_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ie_wr = 1'b0;
  logic       ie_data = 1'b0;
  logic       ack_n = 1'b1;
  logic [7:0] pdata;
  logic       obf_n;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  strobed_out_chan i_strobed_out_chan (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .ie_wr(ie_wr), .ie_data(ie_data), .ack_n(ack_n),
    .pdata(pdata), .obf_n(obf_n), .irq(irq)
  );

  // each vector: {enable, byte}; expected irq after the handshake equals enable
  localparam int NV = 6;
  localparam logic [8:0] VEC [NV] = '{
    9'h1_A5, 9'h0_3C, 9'h1_FF, 9'h1_00, 9'h0_81, 9'h1_5A
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic set_ie(input logic v);
    @(negedge clk); ie_wr = 1'b1; ie_data = v;
    @(negedge clk); ie_wr = 1'b0;
  endtask

  // low phase checks obf_n timing; high phase leaves irq settled
  task automatic ack_pulse(input logic exp_full_release, input logic exp_irq, input string tag);
    @(negedge clk); ack_n = 1'b0;
    repeat (2) @(negedge clk);
    if (exp_full_release) chk({tag, " R3 still full after 2 edges"}, obf_n, 1'b0);
    @(negedge clk);
    chk({tag, " R3/R8 obf_n after ack fall"}, obf_n, 1'b1);
    ack_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({tag, " R4 irq not early"}, irq, 1'b0);
    @(negedge clk);
    chk({tag, " R4/R5/R8 irq after ack rise"}, irq, exp_irq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 obf_n", obf_n, 1'b1);
    chk("R9 irq", irq, 1'b0);
    chk("R9 pdata", pdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R8 stray acknowledge before any write (enable set to prove no irq)
    set_ie(1'b1);
    ack_pulse(1'b0, 1'b0, "R8 stray");

    for (int i = 0; i < NV; i++) begin
      set_ie(VEC[i][8]);
      write_byte(VEC[i][7:0]);
      chk("R1 pdata", pdata, VEC[i][7:0]);
      chk("R2 obf_n", obf_n, 1'b0);
      repeat (3) @(negedge clk);
      chk("R3 stays full", obf_n, 1'b0);
      chk("R10 held", pdata, VEC[i][7:0]);
      ack_pulse(1'b1, VEC[i][8], VEC[i][8] ? "vec R4" : "vec R5");
      chk("R10 held after ack", pdata, VEC[i][7:0]);
    end

    // R6 write clears pending irq (last vector left irq high)
    chk("R6 pre irq", irq, 1'b1);
    write_byte(8'h77);
    chk("R6 irq cleared", irq, 1'b0);

    // R10 overwrite while full
    write_byte(8'h99);
    chk("R10 overwrite data", pdata, 8'h99);
    chk("R10 overwrite full", obf_n, 1'b0);
    ack_pulse(1'b1, 1'b1, "R10 after overwrite");

    // R7 clearing the enable drops irq
    set_ie(1'b0);
    chk("R7 irq cleared", irq, 1'b0);

    // R8 second stray ack after transfer complete
    set_ie(1'b1);
    ack_pulse(1'b0, 1'b0, "R8 repeat");

    // R9 reset mid-transfer
    write_byte(8'h42);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset obf_n", obf_n, 1'b1);
    chk("R9 reset pdata", pdata, 8'h00);
    rst_n = 1'b1;
    write_byte(8'h11);
    ack_pulse(1'b1, 1'b0, "R9 enable cleared by reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule